// File: doc/BRIEF.md
# Multi-Step Converter Sequencer and Host Bus Interface

This block is the digital control for a three-step analog-to-digital converter that sits on a microprocessor bus. It takes the active-low select, hold, read and output-enable strobes from the host, passes the level-type strobes through two-flop synchronizers, and detects their falling edges on the internal clock. When hold falls while select is low, it opens the sample switch and then runs the conversion phases. These are an estimator latch, followed by three flash steps with the remainder switch moving from position 1 to position 2 and then to position 3. Each phase lasts a set number of clock cycles. On the last cycle of each phase, the block captures the comparator code presented to it.

When the last step ends, the block packs the captured codes into a 12-bit word and latches it. It then raises end-of-conversion and pulls the active-low interrupt low. A read strobe taken while select is low clears the interrupt. The block has two bus modes. In interrupt mode, the data bus is enabled only while select, read and output enable are all asserted. In fast mode, the bus is driven all the time, so the host can read without waiting for the interrupt.

Top module: `adc_seq_host`

## Requirements
- R1: While rst_ni is low the outputs are at rest: phase_o=0, sw_pos_o=1, sh_open_o=0, eoc_o=0, int_no=1, data_oe_o=0, data_o=0.
- R2: A falling edge of sh_ni while cs_ni is low starts a conversion. phase_o moves from 0 (track) to 1 (estimate), sh_open_o goes high and eoc_o goes low.
- R3: phase_o steps through 1 (estimate), 2 (step 1), 3 (step 2) and 4 (step 3). Each lasts PHASE_CYC cycles. sw_pos_o is 1 in track, estimate and step 1, 2 in step 2, and 3 in step 3.
- R4: code_i is sampled on the last cycle of each phase. The result is {estimate code[1:0], step 1 code[3:0], step 2 code[3:0], step 3 code[1:0]}, most significant first.
- R5: When step 3 ends, phase_o returns to 0 and sh_open_o to 0. In the same cycle eoc_o rises, int_no falls and the new result is latched.
- R6: A falling edge of rd_ni while cs_ni is low sets int_no back to 1.
- R7: A falling edge of sh_ni while phase_o is not 0 is ignored. The running conversion completes on time, and no further conversion follows.
- R8: While cs_ni is high, falling edges of sh_ni and rd_ni have no effect.
- R9: With mode_fast_i low, data_oe_o = !cs_ni && !rd_ni && oe_i, combinationally from the pins. data_o carries the latched result while data_oe_o is high and 0 otherwise.
- R10: With mode_fast_i high, data_oe_o is 1 and data_o shows the latched result whatever the strobes do.
- R11: eoc_o stays high after a conversion until the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sh_ni | input | 1 | Sample/hold strobe; falling edge starts a conversion |
| rd_ni | input | 1 | Read strobe, active low |
| oe_i | input | 1 | Output enable, active high |
| mode_fast_i | input | 1 | 1 = bus always driven, 0 = interrupt/read mode |
| code_i | input | STEP_W | Comparator code for the current phase |
| phase_o | output | 3 | Phase: 0 track, 1 estimate, 2/3/4 flash steps 1/2/3 |
| sw_pos_o | output | 2 | Remainder switch position 1..3 |
| sh_open_o | output | 1 | Sample switch open (holding) |
| eoc_o | output | 1 | End of conversion |
| int_no | output | 1 | Interrupt, active low |
| data_oe_o | output | 1 | Bus driver enable |
| data_o | output | RES_W | Latched result (0 when not enabled) |

## Verification
The bench builds the block with PHASE_CYC=3 and keeps the default code widths. With a short phase, a full conversion of four phases plus synchronizer latency takes only about sixteen cycles. That leaves room for many conversions, and a second hold edge can be placed inside a specific flash step. A three-cycle phase also separates the first cycle of a phase from its last cycle, so capture on the last cycle can be checked, and each phase length is measured directly from phase_o.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_TRACK = 3'd0,
    PH_EST   = 3'd1,
    PH_F1    = 3'd2,
    PH_F2    = 3'd3,
    PH_F3    = 3'd4
  } phase_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
      prev_q <= '1;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int PHASE_CYC = 12,
  parameter int EST_W     = 2,
  parameter int STEP_W    = 4,
  parameter int FINE_W    = 2,
  localparam int RES_W    = EST_W + 2*STEP_W + FINE_W,
  localparam int CNT_W    = $clog2(PHASE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] code_i,
  output phase_e            phase_o,
  output logic [1:0]        sw_pos_o,
  output logic              sh_open_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [EST_W-1:0]   est_q;
  logic [STEP_W-1:0]  f1_q, f2_q;
  logic [RES_W-1:0]   res_q;
  logic               last;

  assign last = (cnt_q == CNT_W'(PHASE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_TRACK;
      cnt_q   <= '0;
      est_q   <= '0;
      f1_q    <= '0;
      f2_q    <= '0;
      res_q   <= '0;
    end else if (phase_q == PH_TRACK) begin
      cnt_q <= '0;
      if (start_i) phase_q <= PH_EST;
    end else if (last) begin
      cnt_q <= '0;
      unique case (phase_q)
        PH_EST: begin est_q <= code_i[EST_W-1:0]; phase_q <= PH_F1; end
        PH_F1:  begin f1_q  <= code_i;            phase_q <= PH_F2; end
        PH_F2:  begin f2_q  <= code_i;            phase_q <= PH_F3; end
        default: begin
          res_q   <= {est_q, f1_q, f2_q, code_i[FINE_W-1:0]};
          phase_q <= PH_TRACK;
        end
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_F2:   sw_pos_o = 2'd2;
      PH_F3:   sw_pos_o = 2'd3;
      default: sw_pos_o = 2'd1;
    endcase
  end

  assign phase_o   = phase_q;
  assign sh_open_o = (phase_q != PH_TRACK);
  assign done_o    = (phase_q == PH_F3) && last;
  assign result_o  = res_q;
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic rd_clr_i,
  output logic eoc_o,
  output logic int_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_o  <= 1'b0;
      int_no <= 1'b1;
    end else begin
      if (done_i)       eoc_o <= 1'b1;
      else if (start_i) eoc_o <= 1'b0;
      // completion wins over a simultaneous read
      if (done_i)        int_no <= 1'b0;
      else if (rd_clr_i) int_no <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
  import adc_seq_pkg::*;
#(
  parameter int PHASE_CYC   = 12,
  parameter int SYNC_STAGES = 2,
  parameter int EST_W       = 2,
  parameter int STEP_W      = 4,
  parameter int FINE_W      = 2,
  localparam int RES_W      = EST_W + 2*STEP_W + FINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sh_ni,
  input  logic              rd_ni,
  input  logic              oe_i,
  input  logic              mode_fast_i,
  input  logic [STEP_W-1:0] code_i,
  output logic [2:0]        phase_o,
  output logic [1:0]        sw_pos_o,
  output logic              sh_open_o,
  output logic              eoc_o,
  output logic              int_no,
  output logic              data_oe_o,
  output logic [RES_W-1:0]  data_o
);
  localparam int CS_B = 0, SH_B = 1, RD_B = 2;

  logic [2:0]       strobe_q, strobe_fall;
  logic             start_w, rd_clr_w, done_w, busy_w;
  logic [RES_W-1:0] result_w;
  phase_e           phase_w;

  adc_seq_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rd_ni, sh_ni, cs_ni}),
    .q_o    (strobe_q),
    .fall_o (strobe_fall)
  );

  assign busy_w   = (phase_w != PH_TRACK);
  assign start_w  = strobe_fall[SH_B] & ~strobe_q[CS_B] & ~busy_w;
  assign rd_clr_w = strobe_fall[RD_B] & ~strobe_q[CS_B];

  adc_seq_fsm #(
    .PHASE_CYC (PHASE_CYC),
    .EST_W     (EST_W),
    .STEP_W    (STEP_W),
    .FINE_W    (FINE_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .code_i    (code_i),
    .phase_o   (phase_w),
    .sw_pos_o  (sw_pos_o),
    .sh_open_o (sh_open_o),
    .done_o    (done_w),
    .result_o  (result_w)
  );

  adc_seq_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_w),
    .done_i   (done_w),
    .rd_clr_i (rd_clr_w),
    .eoc_o    (eoc_o),
    .int_no   (int_no)
  );

  // bus enable follows the raw pins so the host sees no clock latency
  assign data_oe_o = mode_fast_i | (~cs_ni & ~rd_ni & oe_i);
  assign data_o    = data_oe_o ? result_w : '0;
  assign phase_o   = phase_w;
endmodule

// File: rtl/adc_seq_host_chk.sv
module adc_seq_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] phase_i,
  input logic       eoc_i,
  input logic       int_ni,
  input logic       sh_open_i,
  input logic       start_i,
  input logic       rd_clr_i
);
  // R5
  eoc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_i) |-> ($past(phase_i) == 3'd4 && phase_i == 3'd0 && !sh_open_i));

  // R2
  eoc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_i) |-> (phase_i == 3'd1));

  // R5
  int_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_ni) |-> (eoc_i && phase_i == 3'd0));

  // R6
  int_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_ni) |-> $past(rd_clr_i));

  // R3
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != $past(phase_i)) |->
      (phase_i == $past(phase_i) + 3'd1 || (phase_i == 3'd0 && $past(phase_i) == 3'd4)));

  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && phase_i == 3'd0) |=> (phase_i == 3'd1 && sh_open_i));
endmodule

bind adc_seq_host adc_seq_host_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase_i   (phase_o),
  .eoc_i     (eoc_o),
  .int_ni    (int_no),
  .sh_open_i (sh_open_o),
  .start_i   (start_w),
  .rd_clr_i  (rd_clr_w)
);

// File: tb/tb_adc_seq_host.sv
module tb_adc_seq_host;
  localparam int PC = 3;
  localparam int SW = 4;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sh_ni = 1'b1, rd_ni = 1'b1, oe_i = 1'b0, mode_fast_i = 1'b0;
  logic [SW-1:0] code_i;
  logic [2:0]    phase_o;
  logic [1:0]    sw_pos_o;
  logic          sh_open_o, eoc_o, int_no, data_oe_o;
  logic [RW-1:0] data_o;

  int total = 0;
  int bad = 0;
  logic [RW-1:0] expq[$];
  logic [RW-1:0] last_exp = '0;
  logic [SW-1:0] tbl [8];

  always #2 clk = ~clk;

  adc_seq_host #(.PHASE_CYC(PC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sh_ni(sh_ni), .rd_ni(rd_ni),
    .oe_i(oe_i), .mode_fast_i(mode_fast_i), .code_i(code_i), .phase_o(phase_o),
    .sw_pos_o(sw_pos_o), .sh_open_o(sh_open_o), .eoc_o(eoc_o), .int_no(int_no),
    .data_oe_o(data_oe_o), .data_o(data_o)
  );

  // comparator model: one code per phase
  always_comb code_i = tbl[phase_o];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: phase lengths, switch position, scoreboard pop on completion
  logic [2:0] prev_ph = 3'd0;
  logic       prev_eoc = 1'b0;
  int         run = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (phase_o != prev_ph) begin
        if (prev_ph != 3'd0) chk("R3 phase length", run, PC);
        run = 1;
      end else run++;
      if (phase_o != 3'd0)
        chk("R3 switch position", {30'd0, sw_pos_o},
            (phase_o <= 3'd2) ? 32'd1 : (phase_o == 3'd3) ? 32'd2 : 32'd3);
      if (eoc_o && !prev_eoc) begin
        if (expq.size() == 0) chk("R7 unexpected completion", 1, 0);
        else begin
          last_exp = expq.pop_front();
          chk("R5 int low at completion", {31'd0, int_no}, 0);
          chk("R5 back to track", {29'd0, phase_o}, 0);
          if (data_oe_o) chk("R4 result on bus", {20'd0, data_o}, {20'd0, last_exp});
        end
      end
      prev_ph  = phase_o;
      prev_eoc = eoc_o;
    end
  end

  task automatic conv(input logic [SW-1:0] e, a, b, c, input bit busy_pulse);
    int n;
    tbl[1] = e; tbl[2] = a; tbl[3] = b; tbl[4] = c;
    expq.push_back({e[1:0], a, b, c[1:0]});
    @(negedge clk) sh_ni = 1'b0;
    n = 0;
    while (phase_o == 3'd0 && n < 8) begin @(negedge clk); n++; end
    chk("R2 estimate phase entered", {29'd0, phase_o}, 1);
    chk("R2 eoc low on start", {31'd0, eoc_o}, 0);
    chk("R2 sample switch open", {31'd0, sh_open_o}, 1);
    sh_ni = 1'b1;
    if (busy_pulse) begin
      n = 0;
      while (phase_o != 3'd2 && n < 20) begin @(negedge clk); n++; end
      sh_ni = 1'b0;
      repeat (2) @(negedge clk);
      sh_ni = 1'b1;
    end
    n = 0;
    while (!eoc_o && n < 40) begin @(negedge clk); n++; end
    chk("R5 eoc high", {31'd0, eoc_o}, 1);
    @(negedge clk);
    chk("R5 sample switch closed", {31'd0, sh_open_o}, 0);
    chk("R5 switch at position 1", {30'd0, sw_pos_o}, 1);
  endtask

  task automatic host_read();
    @(negedge clk) rd_ni = 1'b0;
    #1 chk("R9 no drive without oe", {31'd0, data_oe_o}, 0);
    chk("R9 bus zero when idle", {20'd0, data_o}, 0);
    @(negedge clk) oe_i = 1'b1;
    #1 chk("R9 drive with cs rd oe", {31'd0, data_oe_o}, 1);
    chk("R4 result read", {20'd0, data_o}, {20'd0, last_exp});
    repeat (4) @(negedge clk);
    chk("R6 int cleared by read", {31'd0, int_no}, 1);
    rd_ni = 1'b1; oe_i = 1'b0;
    #1 chk("R9 drive released", {31'd0, data_oe_o}, 0);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 phase", {29'd0, phase_o}, 0);
    chk("R1 sw_pos", {30'd0, sw_pos_o}, 1);
    chk("R1 sh_open", {31'd0, sh_open_o}, 0);
    chk("R1 eoc", {31'd0, eoc_o}, 0);
    chk("R1 int", {31'd0, int_no}, 1);
    chk("R1 data_oe", {31'd0, data_oe_o}, 0);
    chk("R1 data", {20'd0, data_o}, 0);
    rst_ni = 1'b1;
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);

    // high code bits of estimate and step 3 must be dropped
    conv(4'hE, 4'h5, 4'hA, 4'h7, 1'b0);
    repeat (6) @(negedge clk);
    chk("R11 eoc held", {31'd0, eoc_o}, 1);
    chk("R11 int held", {31'd0, int_no}, 0);
    host_read();

    // second hold edge in the middle of step 1
    conv(4'h1, 4'hC, 4'h3, 4'h2, 1'b1);
    repeat (10) @(negedge clk);
    chk("R7 busy edge ignored", {29'd0, phase_o}, 0);
    chk("R7 eoc still high", {31'd0, eoc_o}, 1);
    chk("R7 no queued conversion", expq.size(), 0);

    // deselected strobes
    cs_ni = 1'b1;
    repeat (4) @(negedge clk);
    sh_ni = 1'b0; repeat (3) @(negedge clk); sh_ni = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 hold ignored", {29'd0, phase_o}, 0);
    chk("R8 eoc unchanged", {31'd0, eoc_o}, 1);
    rd_ni = 1'b0; repeat (4) @(negedge clk); rd_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 read ignored", {31'd0, int_no}, 0);
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    host_read();

    // fast mode
    mode_fast_i = 1'b1;
    #1 chk("R10 always driven", {31'd0, data_oe_o}, 1);
    chk("R10 result visible", {20'd0, data_o}, {20'd0, last_exp});
    conv(4'hF, 4'hF, 4'hF, 4'hF, 1'b0);
    chk("R10 all ones", {20'd0, data_o}, 32'hFFF);
    conv(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    chk("R10 all zeros", {20'd0, data_o}, 0);
    cs_ni = 1'b1;
    #1 chk("R10 driven while deselected", {31'd0, data_oe_o}, 1);
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule